// File: doc/BRIEF.md
# Three-Wire Register Access Slave

This block is a serial slave port with an active-low select, a serial clock and one data line that changes direction during reads. The system clock oversamples the serial clock. Each transaction starts with a 9-bit control word: a 3-bit tag that must read 101, a direction bit and a 5-bit register index. Together, the tag and the index address the window 0xA0 to 0xBF. A write is followed by a 16-bit word from the master. A read pauses for half a serial clock period, and then the slave shifts out a 16-bit word.

A small register file sits behind the port. Three argument registers are at 0xA1 to 0xA3 and the command register is at 0xA0. Writing the command register last hands the command and its arguments to the core as a one-cycle strobe. The core loads eight response registers at 0xA8 to 0xAF, and the master reads them back. A transaction is closed by raising the select and then giving one more high-then-low serial clock pulse.

Top module: `tw_reg_slave`

## Requirements
- R1: Reset clears the command strobe, the command word, every argument and response register, and leaves the data line undriven (`sdio_oe_o` low).
- R2: After the select falls, the first 9 serial clock rising edges capture the control word MSB first: tag bits 8..6, direction bit 5 (1 = read, 0 = write), index bits 4..0. The index selects register 0xA0 + index.
- R3: In a write, the next 16 rising edges capture the data word MSB first, and the addressed register takes it on the 16th bit. The argument registers at indices 1..3 read back what was last written to them.
- R4: In a read, the line stays undriven until the first rising edge after the control word. From that edge on, the slave drives bit 15, and each later rising edge advances one bit toward bit 0.
- R5: If the tag is not 101, the rest of the transaction is ignored: no register changes and the data line is never driven.
- R6: A completed write to index 0 raises `cmd_valid_o` for exactly one system clock. During that cycle, `cmd_word_o` holds the written word and `cmd_args_o` holds argument 1 at bits 15:0, argument 2 at bits 31:16 and argument 3 at bits 47:32.
- R7: When `resp_we_i` is high at a clock edge, the core stores `resp_data_i` into response slot `resp_idx_i`. Slot k is read at index 8 + k (0xA8 + k).
- R8: A bus write to the response region (indices 8..15) changes nothing. Indices with no register (4..7, 16..31) read 0x0000.
- R9: Once the select is high, the slave releases the data line within 4 system clock cycles.
- R10: After the select rises, a new transaction is accepted only once a high-then-low serial clock pulse has occurred while the select is high. Anything sent before that pulse is ignored.
- R11: If a write is cut short by the select rising before its 16th data bit, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| sen_ni | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Serial data line as seen at the pad |
| sdio_o | output | 1 | Serial data driven by the slave |
| sdio_oe_o | output | 1 | Output enable for the data line |
| cmd_valid_o | output | 1 | One-cycle strobe: a command has been written |
| cmd_word_o | output | 16 | Last command word written |
| cmd_args_o | output | 48 | Argument registers 1..3, packed |
| resp_we_i | input | 1 | Core write strobe for the response region |
| resp_idx_i | input | 3 | Response slot selected by the core |
| resp_data_i | input | 16 | Response data from the core |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 5-bit index, three arguments, eight response slots and a two-stage synchronizer. The serial clock runs twenty times slower than the system clock, so each serial phase spans ten system cycles. At that ratio the synchronizer latency, the release time and the one-cycle command strobe can all be observed at exact system-clock points. With the default index width, every special region can be reached: the command and argument registers, the gap between the arguments and the responses, both ends of the response region, and the unused upper half of the index space.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WDATA,
    ST_RTURN,
    ST_RDATA,
    ST_SKIP,
    ST_CLOSE
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sen_ni,
  input  logic sdio_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic sen_hi_o,
  output logic sdio_o
);
  logic [STAGES-1:0] sclk_q, sen_q, sdio_q;
  logic              sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      sen_q  <= '1;
      sdio_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      sen_q  <= {sen_q[STAGES-2:0], sen_ni};
      sdio_q <= {sdio_q[STAGES-2:0], sdio_i};
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = ~sclk_q[STAGES-1] & sclk_d;
  assign sen_hi_o    = sen_q[STAGES-1];
  assign sdio_o      = sdio_q[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
module tw_frame
  import tw_pkg::*;
#(
  parameter int             DW  = 16,
  parameter int             IW  = 5,
  parameter int             TW  = 3,
  parameter logic [TW-1:0]  TAG = 3'b101
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sen_hi_i,
  input  logic          sdio_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          wr_en_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdio_o,
  output logic          sdio_oe_o
);
  localparam int CW    = TW + 1 + IW;
  localparam int MAXB  = (CW > DW) ? CW : DW;
  localparam int CNT_W = $clog2(MAXB + 1);

  tw_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CW-1:0]    ctrl_q, ctrl_nx;
  logic [DW-1:0]    sh_q;
  logic             oe_q, wr_en_q;

  assign ctrl_nx  = {ctrl_q[CW-2:0], sdio_i};
  assign rd_idx_o = ctrl_nx[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      wr_en_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (sen_hi_i && state_q != ST_IDLE && state_q != ST_CLOSE) begin
        // select high ends the frame; partial writes are dropped
        state_q <= ST_CLOSE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (!sen_hi_i) begin
            state_q <= ST_CTRL;
            cnt_q   <= '0;
          end
          ST_CTRL: if (sclk_rise_i) begin
            ctrl_q <= ctrl_nx;
            cnt_q  <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(CW - 1)) begin
              cnt_q <= '0;
              if (ctrl_nx[CW-1 -: TW] != TAG) state_q <= ST_SKIP;
              else if (ctrl_nx[IW]) begin
                state_q <= ST_RTURN;
                sh_q    <= rd_data_i;
              end else state_q <= ST_WDATA;
            end
          end
          ST_WDATA: if (sclk_rise_i) begin
            sh_q  <= {sh_q[DW-2:0], sdio_i};
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(DW - 1)) begin
              wr_en_q <= 1'b1;
              state_q <= ST_SKIP;
            end
          end
          ST_RTURN: if (sclk_rise_i) begin
            oe_q    <= 1'b1;
            state_q <= ST_RDATA;
          end
          ST_RDATA: if (sclk_rise_i) sh_q <= {sh_q[DW-2:0], 1'b0};
          ST_SKIP: ;
          ST_CLOSE: if (sclk_fall_i && sen_hi_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = ctrl_q[IW-1:0];
  assign wr_data_o = sh_q;
  assign sdio_oe_o = oe_q;
  assign sdio_o    = oe_q & sh_q[DW-1];
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int DW        = 16,
  parameter int IW        = 5,
  parameter int ARG_N     = 3,
  parameter int RESP_BASE = 8,
  parameter int RESP_N    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IW-1:0]             wr_idx_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [IW-1:0]             rd_idx_i,
  output logic [DW-1:0]             rd_data_o,
  input  logic                      resp_we_i,
  input  logic [$clog2(RESP_N)-1:0] resp_idx_i,
  input  logic [DW-1:0]             resp_data_i,
  output logic                      cmd_valid_o,
  output logic [DW-1:0]             cmd_word_o,
  output logic [ARG_N*DW-1:0]       cmd_args_o
);
  localparam int RIW = $clog2(RESP_N);

  logic [DW-1:0] cmd_q;
  logic          cmd_vld_q;
  logic [DW-1:0] arg_q  [ARG_N];
  logic [DW-1:0] resp_q [RESP_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      cmd_vld_q <= 1'b0;
      for (int i = 0; i < ARG_N; i++)  arg_q[i]  <= '0;
      for (int i = 0; i < RESP_N; i++) resp_q[i] <= '0;
    end else begin
      cmd_vld_q <= 1'b0;
      if (wr_en_i && wr_idx_i == '0) begin
        cmd_q     <= wr_data_i;
        cmd_vld_q <= 1'b1;
      end
      for (int i = 0; i < ARG_N; i++)
        if (wr_en_i && wr_idx_i == IW'(i + 1)) arg_q[i] <= wr_data_i;
      // response region is loaded only by the core
      for (int i = 0; i < RESP_N; i++)
        if (resp_we_i && resp_idx_i == RIW'(i)) resp_q[i] <= resp_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_idx_i == '0) rd_data_o = cmd_q;
    for (int i = 0; i < ARG_N; i++)
      if (rd_idx_i == IW'(i + 1)) rd_data_o = arg_q[i];
    for (int i = 0; i < RESP_N; i++)
      if (rd_idx_i == IW'(RESP_BASE + i)) rd_data_o = resp_q[i];
  end

  for (genvar g = 0; g < ARG_N; g++) begin : g_arg
    assign cmd_args_o[g*DW +: DW] = arg_q[g];
  end

  assign cmd_valid_o = cmd_vld_q;
  assign cmd_word_o  = cmd_q;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int           DATA_W      = 16,
  parameter int           IDX_W       = 5,
  parameter int           TAG_W       = 3,
  parameter logic [2:0]   TAG         = 3'b101,
  parameter int           ARG_N       = 3,
  parameter int           RESP_BASE   = 8,
  parameter int           RESP_N      = 8,
  parameter int           SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sclk_i,
  input  logic                          sen_ni,
  input  logic                          sdio_i,
  output logic                          sdio_o,
  output logic                          sdio_oe_o,
  output logic                          cmd_valid_o,
  output logic [DATA_W-1:0]             cmd_word_o,
  output logic [ARG_N*DATA_W-1:0]       cmd_args_o,
  input  logic                          resp_we_i,
  input  logic [$clog2(RESP_N)-1:0]     resp_idx_i,
  input  logic [DATA_W-1:0]             resp_data_i
);
  logic              sclk_rise, sclk_fall, sen_hi, sdio_s;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data;

  tw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .sen_ni, .sdio_i,
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .sen_hi_o    (sen_hi),
    .sdio_o      (sdio_s)
  );

  tw_frame #(.DW(DATA_W), .IW(IDX_W), .TW(TAG_W), .TAG(TAG[TAG_W-1:0])) u_frame (
    .clk_i, .rst_ni,
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .sen_hi_i    (sen_hi),
    .sdio_i      (sdio_s),
    .rd_data_i   (rd_data),
    .rd_idx_o    (rd_idx),
    .wr_en_o     (wr_en),
    .wr_idx_o    (wr_idx),
    .wr_data_o   (wr_data),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o)
  );

  tw_regfile #(
    .DW(DATA_W), .IW(IDX_W), .ARG_N(ARG_N), .RESP_BASE(RESP_BASE), .RESP_N(RESP_N)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_data_i   (wr_data),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .resp_we_i, .resp_idx_i, .resp_data_i,
    .cmd_valid_o, .cmd_word_o, .cmd_args_o
  );
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int IW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sen_hi,
  input logic          sclk_rise,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic          sdio_oe_o,
  input logic          cmd_valid_o
);
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_hi |=> !sdio_oe_o);

  assert_drive_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(sclk_rise));

  assert_cmd_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_cmd_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ($past(wr_en) && $past(wr_idx) == '0));

  assert_drive_after_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> !$past(sen_hi));
endmodule

bind tw_reg_slave tw_reg_slave_chk #(.IW(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sen_hi      (sen_hi),
  .sclk_rise   (sclk_rise),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .sdio_oe_o   (sdio_oe_o),
  .cmd_valid_o (cmd_valid_o)
);

// File: tb/tb_tw_reg_slave.sv
`timescale 1ns/1ps
module tb_tw_reg_slave;
  localparam int HALF = 40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0, sen_ni = 1'b1, sdio_i = 1'b0;
  logic        sdio_o, sdio_oe_o, cmd_valid_o;
  logic [15:0] cmd_word_o;
  logic [47:0] cmd_args_o;
  logic        resp_we_i = 1'b0;
  logic [2:0]  resp_idx_i = '0;
  logic [15:0] resp_data_i = '0;

  int checks = 0, errors = 0, pulses = 0;
  logic [15:0] cap_cmd;
  logic [47:0] cap_args;
  bit done = 0;

  always #2 clk = ~clk;

  tw_reg_slave dut (
    .clk_i(clk), .rst_ni, .sclk_i, .sen_ni, .sdio_i, .sdio_o, .sdio_oe_o,
    .cmd_valid_o, .cmd_word_o, .cmd_args_o, .resp_we_i, .resp_idx_i, .resp_data_i
  );

  always @(negedge clk) if (cmd_valid_o) begin
    pulses++;
    cap_cmd  = cmd_word_o;
    cap_args = cmd_args_o;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdio_i = b; #HALF; sclk_i = 1'b1; #HALF; sclk_i = 1'b0;
  endtask

  task automatic send_ctrl(input logic [2:0] tag, input logic rd, input logic [4:0] idx);
    logic [8:0] w;
    w = {tag, rd, idx};
    for (int i = 8; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic end_xfer(output logic oe_after);
    sdio_i = 1'b0; sen_ni = 1'b1; #16;
    oe_after = sdio_oe_o;
    #(HALF-16); sclk_i = 1'b1; #HALF; sclk_i = 1'b0; #HALF;
  endtask

  task automatic bus_write(input logic [2:0] tag, input logic [4:0] idx,
                           input logic [15:0] d, input int nbits);
    logic oe;
    sen_ni = 1'b0; #HALF;
    send_ctrl(tag, 1'b0, idx);
    for (int i = 15; i > 15 - nbits; i--) send_bit(d[i]);
    end_xfer(oe);
  endtask

  task automatic bus_read(input logic [2:0] tag, input logic [4:0] idx, output logic [15:0] d,
                          output logic all_oe, output logic any_oe,
                          output logic turn_oe, output logic rel_oe);
    sen_ni = 1'b0; #HALF;
    send_ctrl(tag, 1'b1, idx);
    sdio_i = 1'b0; #HALF;
    turn_oe = sdio_oe_o;
    all_oe = 1'b1; any_oe = 1'b0; d = '0;
    for (int i = 0; i < 16; i++) begin
      sclk_i = 1'b1; #(HALF-4);
      all_oe &= sdio_oe_o; any_oe |= sdio_oe_o;
      d = {d[14:0], sdio_o};
      #4; sclk_i = 1'b0; #HALF;
    end
    end_xfer(rel_oe);
  endtask

  task automatic core_load(input logic [2:0] k, input logic [15:0] d);
    @(negedge clk); resp_we_i = 1'b1; resp_idx_i = k; resp_data_i = d;
    @(negedge clk); resp_we_i = 1'b0;
  endtask

  task automatic rd_expect(input string req, input logic [4:0] idx, input logic [15:0] exp);
    logic [15:0] d; logic a, n, t, r;
    bus_read(3'b101, idx, d, a, n, t, r);
    chk({req, " data"}, d, exp);
    chk("R4 driven every bit", a, 1'b1);
    chk("R4 undriven in turnaround", t, 1'b0);
    chk("R9 released after select", r, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 oe", sdio_oe_o, 1'b0);
    chk("R1 cmd_valid", cmd_valid_o, 1'b0);
    chk("R1 cmd_word", cmd_word_o, 16'h0);
    chk("R1 args", cmd_args_o, 48'h0);
    rd_expect("R1 resp slot 0", 5'd8, 16'h0);
  endtask

  task automatic t_args;
    bus_write(3'b101, 5'd1, 16'h1234, 16);
    bus_write(3'b101, 5'd2, 16'hBEEF, 16);
    bus_write(3'b101, 5'd3, 16'h0F0F, 16);
    chk("R3 no strobe on arg writes", pulses, 0);
    rd_expect("R2 R3 arg1", 5'd1, 16'h1234);
    rd_expect("R3 arg2", 5'd2, 16'hBEEF);
    rd_expect("R3 arg3", 5'd3, 16'h0F0F);
  endtask

  task automatic t_cmd;
    bus_write(3'b101, 5'd0, 16'h00C5, 16);
    chk("R6 one pulse", pulses, 1);
    chk("R6 cmd word", cap_cmd, 16'h00C5);
    chk("R6 args", cap_args, 48'h0F0F_BEEF_1234);
    rd_expect("R6 cmd readback", 5'd0, 16'h00C5);
  endtask

  task automatic t_resp;
    core_load(3'd0, 16'hA55A);
    core_load(3'd7, 16'h8001);
    rd_expect("R7 slot 0", 5'd8, 16'hA55A);
    rd_expect("R7 slot 7", 5'd15, 16'h8001);
  endtask

  task automatic t_ignore;
    core_load(3'd2, 16'h3C3C);
    bus_write(3'b101, 5'd10, 16'hFFFF, 16);
    rd_expect("R8 resp not bus writable", 5'd10, 16'h3C3C);
    bus_write(3'b101, 5'd5, 16'h7777, 16);
    rd_expect("R8 gap reads zero", 5'd5, 16'h0);
    bus_write(3'b101, 5'd31, 16'h7777, 16);
    rd_expect("R8 top reads zero", 5'd31, 16'h0);
    chk("R8 no strobe", pulses, 1);
  endtask

  task automatic t_bad_tag;
    logic [15:0] d; logic a, n, t, r;
    bus_write(3'b100, 5'd1, 16'hDEAD, 16);
    bus_write(3'b001, 5'd0, 16'hDEAD, 16);
    chk("R5 no strobe", pulses, 1);
    rd_expect("R5 arg1 kept", 5'd1, 16'h1234);
    bus_read(3'b111, 5'd8, d, a, n, t, r);
    chk("R5 never drives", n, 1'b0);
  endtask

  task automatic t_abort;
    bus_write(3'b101, 5'd2, 16'h5555, 8);
    rd_expect("R11 arg2 kept", 5'd2, 16'hBEEF);
  endtask

  task automatic t_close;
    logic oe;
    sen_ni = 1'b0; #HALF;
    send_ctrl(3'b101, 1'b0, 5'd3);
    for (int i = 15; i >= 0; i--) send_bit(16'h2222 >> i);
    sen_ni = 1'b1; #HALF;          // no closing pulse
    sen_ni = 1'b0; #HALF;
    send_ctrl(3'b101, 1'b0, 5'd3);
    for (int i = 15; i >= 0; i--) send_bit(16'h3333 >> i);
    end_xfer(oe);
    rd_expect("R10 frame before close ignored", 5'd3, 16'h2222);
    bus_write(3'b101, 5'd3, 16'h4444, 16);
    rd_expect("R10 accepted after close", 5'd3, 16'h4444);
  endtask

  initial begin
    #700000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #20 rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_args();
    t_cmd();
    t_resp();
    t_ignore();
    t_bad_tag();
    t_abort();
    t_close();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule